// File: doc/BRIEF.md
# Haar Wavelet OFDM Symbol Modem

This block holds the transmit and receive halves of a multicarrier symbol modem. In place of an inverse FFT and an FFT it uses a one-level inverse Haar transform and a one-level forward Haar transform. On the transmit side, 64 symbol levels arrive one at a time and are stored. The frame is then read back in a transposed order. Each symbol goes into the approximation branch of the synthesis stage, and the detail branch is held at zero. The block streams out 128 samples with no cyclic prefix.

On the receive side, incoming samples are grouped into pairs. Each pair is reduced to its low-band (sum) term, which is halved with rounding and then clipped to the symbol range. The result is written back to its untransposed position. When a full frame has arrived, the block emits the 64 recovered symbols serially. A frame marker on the sample input sets the receiver's alignment. The two halves can be chained directly, transmit output to receive input, for a loopback.

Top module: `wofdm_modem`

## Requirements
- R1: While reset is asserted, `txReady` is 1, and `smpValid` and `symOutValid` are both 0.
- R2: `txReady` stays high until the 64th symbol is accepted. `smpValid` then goes high on the clock after the accepting edge and stays high for exactly 128 consecutive cycles. `txReady` is low from the accepting edge until the edge that registers the last sample.
- R3: Symbols are numbered 0..63 in order of acceptance. Output pair p (p = 0..63) carries symbol number 8*(p mod 8) + p div 8, which is an 8x8 row/column transpose.
- R4: The detail branch is zero, so both samples of a pair equal the symbol value, as 8-bit two's complement. A frame is exactly 128 samples and has no prefix.
- R5: `smpFirst` is high only together with the first sample of each frame.
- R6: A symbol presented with `symInFirst` high is stored as symbol number 0. Any partly loaded frame is abandoned, and loading restarts from that symbol.
- R7: Consecutive received samples x0, x1 form one pair. The recovered value is floor((x0 + x1 + 1) / 2), clipped to the range 0..63.
- R8: The value recovered from received pair p is placed at output position 8*(p mod 8) + p div 8.
- R9: After the edge that takes the 128th sample of a frame, `symOutValid` rises one clock later and stays high for 64 cycles. It carries output positions 0..63 in order, and `symOutFirst` is high only on position 0.
- R10: A sample with `rxFirst` high becomes sample 0 of a new frame. Samples taken after reset but before the first `rxFirst` are ignored and produce no output.
- R11: Cycles with `rxValid` low are skipped. After 128 samples the count wraps, so a following frame needs no `rxFirst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| symInValid | input | 1 | Symbol input valid |
| symInFirst | input | 1 | Marks symbol 0 of a transmit frame |
| symIn | input | 6 | Symbol level 0..63 |
| txReady | output | 1 | Transmit side is loading and accepts symbols |
| smpOut | output | 8 | Transmitted sample, signed |
| smpValid | output | 1 | Transmitted sample valid |
| smpFirst | output | 1 | First sample of a transmitted frame |
| rxValid | input | 1 | Received sample valid |
| rxFirst | input | 1 | Marks sample 0 of a received frame |
| rxSmp | input | 8 | Received sample, signed |
| symOutValid | output | 1 | Recovered symbol valid |
| symOutFirst | output | 1 | First recovered symbol of a frame |
| symOut | output | 6 | Recovered symbol level |

## Verification
A corrupted transmit counter or buffer address shows up on the very next sample. The transmitted value, the pair duplication or the `smpFirst` position then differs from the reference, and a lost count also shifts the 128-cycle window and the return of `txReady`. A wrong receive pair index or a wrong transpose stays hidden until the frame is released. It then appears as misplaced symbols within the 64 output cycles that follow. The reference model is compared on every clock for both halves, in loopback and with directly driven noisy, gapped and resynchronised sample streams, so a fault is reported within one frame time of its cause.

// File: rtl/wofdm_pkg.sv
package wofdm_pkg;

  // Strobes from the sequencer to the datapath, one bit per action.
  typedef struct packed {
    logic txLoad;   // write one symbol into the transmit store
    logic txEmit;   // register one synthesis sample
    logic rxHold;   // keep the even sample of a pair
    logic rxStore;  // write a recovered symbol
    logic rxCopy;   // move the finished frame into the output shifter
    logic rxShift;  // advance the output shifter
  } ctlStrobes_t;

endpackage

// File: rtl/wofdm_ctrl.sv
module wofdm_ctrl
  import wofdm_pkg::*;
#(
  parameter int GRID_LOG = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  symInValid,
  input  logic                  symInFirst,
  input  logic                  rxValid,
  input  logic                  rxFirst,
  output logic                  txReady,
  output ctlStrobes_t           strb,
  output logic [2*GRID_LOG-1:0] txWrAddr,
  output logic [2*GRID_LOG:0]   txRdIdx,
  output logic [2*GRID_LOG-1:0] rxPair,
  output logic                  symOutValid,
  output logic                  symOutFirst
);
  localparam int SYM_AW    = 2 * GRID_LOG;
  localparam int SMP_AW    = SYM_AW + 1;
  localparam int FRAME_SYM = 1 << SYM_AW;
  localparam logic [SYM_AW-1:0] LAST_SYM = '1;
  localparam logic [SMP_AW-1:0] LAST_SMP = '1;

  typedef enum logic {TX_LOAD, TX_SEND} txPhase_t;

  txPhase_t          txPhase;
  logic [SYM_AW-1:0] loadCnt;
  logic [SMP_AW-1:0] sendCnt;
  logic              rxSync;
  logic [SMP_AW-1:0] rxCnt;
  logic              copyPend;
  logic              outActive;
  logic [SYM_AW-1:0] outCnt;

  logic              takeSym;
  logic              takeSmp;
  logic [SYM_AW-1:0] loadIdx;
  logic [SMP_AW-1:0] smpIdx;

  always_comb begin
    takeSym = (txPhase == TX_LOAD) && symInValid;
    loadIdx = symInFirst ? '0 : loadCnt;
    takeSmp = rxValid && (rxFirst || rxSync);
    smpIdx  = rxFirst ? '0 : rxCnt;
  end

  always_comb begin
    strb.txLoad  = takeSym;
    strb.txEmit  = (txPhase == TX_SEND);
    strb.rxHold  = takeSmp && !smpIdx[0];
    strb.rxStore = takeSmp && smpIdx[0];
    strb.rxCopy  = copyPend;
    strb.rxShift = outActive;
  end

  assign txWrAddr    = loadIdx;
  assign txRdIdx     = sendCnt;
  assign rxPair      = smpIdx[SMP_AW-1:1];
  assign txReady     = (txPhase == TX_LOAD);
  assign symOutValid = outActive;
  assign symOutFirst = outActive && (outCnt == '0);

  // Transmit sequencing: load 64 symbols, then emit 128 samples.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txPhase <= TX_LOAD;
      loadCnt <= '0;
      sendCnt <= '0;
    end else if (txPhase == TX_LOAD) begin
      if (takeSym) begin
        if (loadIdx == LAST_SYM) begin
          txPhase <= TX_SEND;
          sendCnt <= '0;
          loadCnt <= '0;
        end else begin
          loadCnt <= loadIdx + 1'b1;
        end
      end
    end else begin
      sendCnt <= sendCnt + 1'b1;
      if (sendCnt == LAST_SMP) txPhase <= TX_LOAD;
    end
  end

  // Receive sequencing: pair counting, frame release, serial readout.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSync    <= 1'b0;
      rxCnt     <= '0;
      copyPend  <= 1'b0;
      outActive <= 1'b0;
      outCnt    <= '0;
    end else begin
      if (rxValid && rxFirst) rxSync <= 1'b1;
      if (takeSmp) rxCnt <= smpIdx + 1'b1;
      copyPend <= takeSmp && (smpIdx == LAST_SMP);
      if (copyPend) begin
        outActive <= 1'b1;
        outCnt    <= '0;
      end else if (outActive) begin
        outCnt <= outCnt + 1'b1;
        if (outCnt == LAST_SYM) outActive <= 1'b0;
      end
    end
  end

  // Checker state: length of the current readout run.
  logic [SYM_AW:0] outRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outRun <= '0;
    else       outRun <= symOutValid ? outRun + 1'b1 : '0;
  end

  // R10
  rx_unsynced_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rxSync |-> (!copyPend && !outActive));

  // R9
  out_run_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(symOutValid) |-> (outRun == (SYM_AW+1)'(FRAME_SYM)));

endmodule

// File: rtl/wofdm_dp.sv
module wofdm_dp
  import wofdm_pkg::*;
#(
  parameter int SYM_W    = 6,
  parameter int GRID_LOG = 3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctlStrobes_t                strb,
  input  logic [2*GRID_LOG-1:0]      txWrAddr,
  input  logic [2*GRID_LOG:0]        txRdIdx,
  input  logic [2*GRID_LOG-1:0]      rxPair,
  input  logic [SYM_W-1:0]           symIn,
  input  logic signed [SYM_W+1:0]    rxSmp,
  output logic signed [SYM_W+1:0]    smpOut,
  output logic                       smpValid,
  output logic                       smpFirst,
  output logic [SYM_W-1:0]           symOut
);
  localparam int SYM_AW    = 2 * GRID_LOG;
  localparam int SMP_AW    = SYM_AW + 1;
  localparam int SMP_W     = SYM_W + 2;
  localparam int FRAME_SYM = 1 << SYM_AW;
  localparam int FRAME_SMP = 2 * FRAME_SYM;
  localparam logic signed [SMP_W-1:0] DETAIL  = '0;
  localparam logic signed [SMP_W:0]   RND     = (SMP_W+1)'(1);
  localparam logic signed [SMP_W:0]   SYM_MAX = (SMP_W+1)'((1 << SYM_W) - 1);

  function automatic logic [SYM_AW-1:0] transposeIdx(input logic [SYM_AW-1:0] p);
    return {p[GRID_LOG-1:0], p[SYM_AW-1:GRID_LOG]};
  endfunction

  logic [SYM_W-1:0] txBuf  [FRAME_SYM];
  logic [SYM_W-1:0] rxBuf  [FRAME_SYM];
  logic [SYM_W-1:0] outBuf [FRAME_SYM];
  logic signed [SMP_W-1:0] rxHeld;

  // ---------------- transmit: inverse Haar, detail branch zero
  logic [SYM_AW-1:0]       srcAddr;
  logic signed [SMP_W-1:0] approx;
  logic signed [SMP_W-1:0] synth;

  always_comb begin
    srcAddr = transposeIdx(txRdIdx[SMP_AW-1:1]);
    approx  = signed'({{(SMP_W-SYM_W){1'b0}}, txBuf[srcAddr]});
    synth   = txRdIdx[0] ? (approx - DETAIL) : (approx + DETAIL);
  end

  always_ff @(posedge clk) begin
    if (strb.txLoad) txBuf[txWrAddr] <= symIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      smpValid <= 1'b0;
      smpFirst <= 1'b0;
      smpOut   <= '0;
    end else begin
      smpValid <= strb.txEmit;
      smpFirst <= strb.txEmit && (txRdIdx == '0);
      if (strb.txEmit) smpOut <= synth;
    end
  end

  // ---------------- receive: forward Haar low band, rounding, clipping
  logic signed [SMP_W:0] lowBand;
  logic signed [SMP_W:0] rounded;
  logic [SYM_W-1:0]      recovered;

  always_comb begin
    lowBand = {rxHeld[SMP_W-1], rxHeld} + {rxSmp[SMP_W-1], rxSmp};
    rounded = (lowBand + RND) >>> 1;
    if (rounded[SMP_W])          recovered = '0;
    else if (rounded > SYM_MAX)  recovered = '1;
    else                         recovered = rounded[SYM_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rxHeld <= '0;
    else if (strb.rxHold) rxHeld <= rxSmp;
  end

  always_ff @(posedge clk) begin
    if (strb.rxStore) rxBuf[transposeIdx(rxPair)] <= recovered;
  end

  // Parallel load, serial shift toward entry 0.
  for (genvar i = 0; i < FRAME_SYM; i++) begin : g_shift
    if (i == FRAME_SYM - 1) begin : g_tail
      always_ff @(posedge clk) begin
        if (strb.rxCopy)       outBuf[i] <= rxBuf[i];
        else if (strb.rxShift) outBuf[i] <= '0;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (strb.rxCopy)       outBuf[i] <= rxBuf[i];
        else if (strb.rxShift) outBuf[i] <= outBuf[i+1];
      end
    end
  end

  assign symOut = outBuf[0];

  // Checker state: pair parity and transmit run length.
  logic            chkOdd;
  logic [SMP_AW:0] runLen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chkOdd <= 1'b0;
      runLen <= '0;
    end else begin
      chkOdd <= smpValid ? (smpFirst ? 1'b1 : !chkOdd) : 1'b0;
      runLen <= smpValid ? runLen + 1'b1 : '0;
    end
  end

  // R4
  pair_twin_chk: assert property (@(posedge clk) disable iff (!rstN)
    (smpValid && chkOdd) |-> ($past(smpValid) && smpOut == $past(smpOut)));

  // R2
  tx_run_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(smpValid) |-> (runLen == (SMP_AW+1)'(FRAME_SMP)));

  // R5
  first_after_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    smpFirst |-> (smpValid && !$past(smpValid)));

endmodule

// File: rtl/wofdm_modem.sv
module wofdm_modem
  import wofdm_pkg::*;
#(
  parameter int SYM_W    = 6,
  parameter int GRID_LOG = 3,
  localparam int SMP_W   = SYM_W + 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    symInValid,
  input  logic                    symInFirst,
  input  logic [SYM_W-1:0]        symIn,
  output logic                    txReady,
  output logic signed [SMP_W-1:0] smpOut,
  output logic                    smpValid,
  output logic                    smpFirst,
  input  logic                    rxValid,
  input  logic                    rxFirst,
  input  logic signed [SMP_W-1:0] rxSmp,
  output logic                    symOutValid,
  output logic                    symOutFirst,
  output logic [SYM_W-1:0]        symOut
);
  localparam int SYM_AW = 2 * GRID_LOG;

  ctlStrobes_t       strb;
  logic [SYM_AW-1:0] txWrAddr;
  logic [SYM_AW:0]   txRdIdx;
  logic [SYM_AW-1:0] rxPair;

  wofdm_ctrl #(.GRID_LOG(GRID_LOG)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .symInValid(symInValid), .symInFirst(symInFirst),
    .rxValid(rxValid), .rxFirst(rxFirst),
    .txReady(txReady), .strb(strb),
    .txWrAddr(txWrAddr), .txRdIdx(txRdIdx), .rxPair(rxPair),
    .symOutValid(symOutValid), .symOutFirst(symOutFirst)
  );

  wofdm_dp #(.SYM_W(SYM_W), .GRID_LOG(GRID_LOG)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .txWrAddr(txWrAddr), .txRdIdx(txRdIdx), .rxPair(rxPair),
    .symIn(symIn), .rxSmp(rxSmp),
    .smpOut(smpOut), .smpValid(smpValid), .smpFirst(smpFirst),
    .symOut(symOut)
  );

  // R2
  ready_low_on_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(smpValid) |-> !txReady);

endmodule

// File: tb/wofdm_modem_tb.sv
`timescale 1ns/1ps
module wofdm_modem_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic       symInValid = 0, symInFirst = 0;
  logic [5:0] symIn = '0;
  logic       txReady, smpValid, smpFirst;
  logic signed [7:0] smpOut;
  logic       drvRxValid = 0, drvRxFirst = 0;
  logic signed [7:0] drvRxSmp = '0;
  logic       loopMode = 0;
  logic       rxValidW, rxFirstW;
  logic signed [7:0] rxSmpW;
  logic       symOutValid, symOutFirst;
  logic [5:0] symOut;

  assign rxValidW = loopMode ? smpValid : drvRxValid;
  assign rxFirstW = loopMode ? smpFirst : drvRxFirst;
  assign rxSmpW   = loopMode ? smpOut   : drvRxSmp;

  wofdm_modem u_dut (
    .clk(clk), .rstN(rstN),
    .symInValid(symInValid), .symInFirst(symInFirst), .symIn(symIn),
    .txReady(txReady), .smpOut(smpOut), .smpValid(smpValid), .smpFirst(smpFirst),
    .rxValid(rxValidW), .rxFirst(rxFirstW), .rxSmp(rxSmpW),
    .symOutValid(symOutValid), .symOutFirst(symOutFirst), .symOut(symOut)
  );

  int checks = 0;
  int fails  = 0;

  function automatic void chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endfunction

  // ---------------- behavioural reference model
  bit cRst, cSymV, cSymF, cRxV, cRxF;
  int cSym, cRx;
  int mBuf [64];
  int mRbuf[64];
  int mObuf[64];
  bit mLoading;
  int mLoad, mSend;
  bit mSync, mCopy, mOutAct;
  int mCnt, mX0, mOutIdx;

  function automatic int tr(int p);
    return (p % 8) * 8 + p / 8;
  endfunction

  // capture inputs mid-cycle, while they are stable
  always @(negedge clk) begin
    #1;
    cRst = rstN; cSymV = symInValid; cSymF = symInFirst; cSym = int'(symIn);
    cRxV = rxValidW; cRxF = rxFirstW; cRx = int'(rxSmpW);
  end

  always @(posedge clk) begin
    bit expV, expF;
    int expS;
    #2;
    if (!cRst) begin
      mLoading = 1; mLoad = 0; mSend = 0;
      mSync = 0; mCopy = 0; mOutAct = 0; mCnt = 0; mOutIdx = 0;
      // R1 reset state
      chk(txReady == 1'b1, "R1 txReady", txReady, 1);
      chk(smpValid == 1'b0, "R1 smpValid", smpValid, 0);
      chk(symOutValid == 1'b0, "R1 symOutValid", symOutValid, 0);
    end else begin
      // transmit half
      expV = 0; expF = 0; expS = 0;
      if (!mLoading) begin
        expV = 1; expF = (mSend == 0); expS = mBuf[tr(mSend / 2)];
        mSend++;
        if (mSend == 128) mLoading = 1;
      end else if (cSymV) begin
        int idx;
        idx = cSymF ? 0 : mLoad;
        mBuf[idx] = cSym;
        if (idx == 63) begin mLoading = 0; mSend = 0; mLoad = 0; end
        else mLoad = idx + 1;
      end
      chk(txReady == mLoading, "R2 txReady", txReady, mLoading);
      chk(smpValid == expV, "R2 R4 smpValid", smpValid, expV);
      chk(smpFirst == expF, "R5 smpFirst", smpFirst, expF);
      if (expV) chk(int'(smpOut) == expS, "R3 R4 R6 smpOut", smpOut, expS);

      // receive half
      begin
        bit copyNext;
        if (mCopy) begin mObuf = mRbuf; mOutAct = 1; mOutIdx = 0; end
        else if (mOutAct) begin mOutIdx++; if (mOutIdx == 64) mOutAct = 0; end
        copyNext = 0;
        if (cRxV && (cRxF || mSync)) begin
          int idx, v;
          idx = cRxF ? 0 : mCnt;
          mSync = 1;
          if (idx % 2 == 0) mX0 = cRx;
          else begin
            v = (mX0 + cRx + 1) >>> 1;
            if (v < 0) v = 0;
            if (v > 63) v = 63;
            mRbuf[tr(idx / 2)] = v;
            if (idx == 127) copyNext = 1;
          end
          mCnt = (idx + 1) % 128;
        end
        mCopy = copyNext;
      end
      chk(symOutValid == mOutAct, "R9 R10 R11 symOutValid", symOutValid, mOutAct);
      chk(symOutFirst == (mOutAct && mOutIdx == 0), "R9 symOutFirst", symOutFirst,
          (mOutAct && mOutIdx == 0));
      if (mOutAct) chk(int'(symOut) == mObuf[mOutIdx], "R7 R8 symOut", symOut, mObuf[mOutIdx]);
    end
  end

  // ---------------- stimulus
  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pushFrame(int mulv, int addv);
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      symInValid = 0;
      while (!txReady) @(negedge clk);
      symInValid = 1; symInFirst = (i == 0); symIn = 6'((i * mulv + addv) % 64);
    end
    @(negedge clk);
    symInValid = 0; symInFirst = 0;
  endtask

  task automatic pushSymGap(int v, bit f);
    @(negedge clk);
    symInValid = 1; symInFirst = f; symIn = 6'(v);
    while (!txReady) @(negedge clk);
    @(negedge clk);
    symInValid = 0; symInFirst = 0;
  endtask

  task automatic pushRx(int v, bit f);
    @(negedge clk);
    drvRxValid = 1; drvRxFirst = f; drvRxSmp = 8'(v);
  endtask

  task automatic rxGap();
    @(negedge clk);
    drvRxValid = 0; drvRxFirst = 0;
  endtask

  // one noisy frame: pairs near each other, spanning below 0 and above 63
  task automatic rxFrame(bit withFirst, int seed, bit gaps);
    for (int p = 0; p < 64; p++) begin
      int x0, x1;
      x0 = ((p * 13 + seed) % 90) - 15;
      x1 = x0 + ((p + seed) % 5) - 2;
      pushRx(x0, withFirst && p == 0);
      if (gaps && p % 3 == 0) rxGap();
      pushRx(x1, 1'b0);
    end
    rxGap();
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R2: actual cycles 20000 expected run to end earlier");
    finishRun();
  end

  initial begin
    idle(3);
    // R1: explicit reset observation
    chk(txReady == 1'b1 && smpValid == 1'b0 && symOutValid == 1'b0, "R1 reset outputs",
        {txReady, smpValid, symOutValid}, 3'b100);
    rstN = 1;
    idle(2);

    // loopback: transmit frames fed straight into the receiver
    loopMode = 1;
    pushFrame(1, 0);                 // R3 R4 ascending levels
    idle(250);
    // R6: partial load abandoned by a new frame start, with gaps
    for (int i = 0; i < 10; i++) pushSymGap(50 - i, i == 0);
    pushFrame(37, 5);
    idle(250);
    // back-to-back frames, second waits for txReady (R2)
    pushFrame(63, 63);
    pushFrame(11, 2);
    idle(300);

    // direct receive drive after a fresh reset
    loopMode = 0;
    @(negedge clk); rstN = 0;
    idle(2);
    @(negedge clk); rstN = 1;
    // R10: samples before any frame marker are ignored
    for (int i = 0; i < 40; i++) pushRx(i, 1'b0);
    rxGap();
    idle(80);
    // R7 R8 noisy pairs with gaps, then R11 a frame without a marker
    rxFrame(1'b1, 3, 1'b1);
    rxFrame(1'b0, 17, 1'b0);
    idle(10);
    // R10: partial frame then resync by marker
    for (int i = 0; i < 50; i++) pushRx(i, i == 0);
    rxFrame(1'b1, 29, 1'b1);
    idle(120);
    finishRun();
  end
endmodule